// File: doc/BRIEF.md
# Digital line loss-of-signal detector

This block monitors the recovered bipolar data of a DS3, E3 or STS-1 receive line and raises a loss-of-signal (LOS) indication. On each cycle where the sample strobe is high it takes one pulse interval: a positive-pulse flag and a negative-pulse flag. A pulse of either polarity counts as a mark, and a strobed sample with neither flag counts as a zero. Cycles without the strobe do not count.

LOS is declared after a long unbroken run of zero intervals. Clearing uses a different test: LOS is released only after a long span of intervals in which no excessive-zero run has been seen. The zero-run length that counts as excessive depends on the line mode. The indication is only produced while zero-substitution decoding is enabled. Each change of the LOS state gives a one-cycle event that is latched in a sticky bit. The sticky bit drives an interrupt through an enable input.

Top module: `line_los_monitor`

## Requirements
- R1: With `dec_on`=1 and LOS low, `los_line` and `los_flag` rise at the clock edge that accepts the 192nd consecutive strobed zero sample. A run of 191 zeros does not declare.
- R2: A strobed sample with `mark_pos`=1, with `mark_neg`=1, or with both set, restarts the zero run. After such a sample, a further 192 zeros are needed to declare.
- R3: Cycles with `smp_vld`=0 are ignored whatever the mark inputs are. They neither extend nor restart a zero run, and they do not advance a clean span.
- R4: With `mode_e3`=0 (DS3/STS-1), a zero run that reaches 3 is an excessive-zero event. While LOS is high, LOS clears at the edge that accepts the 192nd consecutive strobed sample that is not part of such an event. Runs of 1 or 2 zeros count toward the span. The sample that makes a run reach 3, and any later zero in that run, restarts the span from zero.
- R5: With `mode_e3`=1 (E3), the excessive-zero threshold is 4 zeros, so runs of up to 3 zeros count toward the clean span.
- R6: `los_line` and `los_flag` are always equal.
- R7: While `dec_on`=0, LOS is low and no change event is produced, even when LOS was high. The zero-run and clean-span counts are cleared, so after re-enabling, a full 192-zero run is needed to declare.
- R8: `cos_evt` is high for exactly the one cycle after each edge at which LOS is declared or cleared by detection. The event sets `cos_sticky`. A high `cos_clr` clears `cos_sticky` at the next edge, unless an event arrives at that same edge, in which case the sticky bit stays set.
- R9: `irq` equals `cos_sticky` AND `irq_en`.
- R10: After reset, `los_line`, `los_flag`, `cos_evt`, `cos_sticky` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered-clock-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; one pulse interval per high cycle |
| mark_pos | input | 1 | Positive pulse present in this interval |
| mark_neg | input | 1 | Negative pulse present in this interval |
| mode_e3 | input | 1 | 1 = E3 (threshold 4 zeros), 0 = DS3/STS-1 (threshold 3) |
| dec_on | input | 1 | Zero-substitution decoding enabled; gates detection |
| irq_en | input | 1 | LOS interrupt enable |
| cos_clr | input | 1 | One-cycle clear of the sticky change bit |
| los_line | output | 1 | LOS pin-level indication |
| los_flag | output | 1 | LOS status bit |
| cos_evt | output | 1 | One-cycle change-of-state event |
| cos_sticky | output | 1 | Latched change-of-state bit |
| irq | output | 1 | Maskable interrupt |

## Verification
Two things can land on the same edge: the software clear of the sticky bit and a fresh change of LOS state. The bench provokes this by holding `cos_clr` high while feeding the 192nd zero. It then expects `cos_evt` and `cos_sticky` both high after that edge. A clear issued on its own afterwards must drop the sticky bit. The declare and clear timing is swept over run lengths around the threshold and over gap lengths on both sides of each mode's excessive-zero limit. In each case the exact sample count at which LOS changes is compared with a count computed arithmetically.

// File: rtl/los_pkg.sv
package los_pkg;

  // Line-mode selector for the excessive-zero threshold
  typedef enum logic {
    LINE_T3 = 1'b0,
    LINE_E3 = 1'b1
  } line_mode_e;

  // Width needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/los_zero_run.sv
// Saturating count of consecutive strobed zero intervals.
module los_zero_run #(
  parameter int unsigned RUN_LEN = 192,
  localparam int unsigned RW     = los_pkg::cnt_width(RUN_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,      // synchronous clear, wins over advance
  input  logic          vld,
  input  logic          mark,
  output logic [RW-1:0] run_adv,   // run length including this sample
  output logic          run_full   // this sample completes RUN_LEN zeros
);
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_d;
  logic          run_ce;

  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN);

  always_comb begin
    run_adv = run_q;
    if (vld) begin
      if (mark)                run_adv = '0;
      else if (run_q < RUN_MAX) run_adv = run_q + 1'b1;
    end
    run_full = vld && !mark && (run_adv == RUN_MAX) && (run_q != RUN_MAX);
  end

  always_comb begin
    run_ce = wipe || vld;
    run_d  = wipe ? '0 : run_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_ce) run_q <= run_d;
  end
endmodule

// File: rtl/los_clean_span.sv
// Counts strobed intervals free of excessive zeros while LOS is held.
module los_clean_span #(
  parameter int unsigned SPAN_LEN = 192,
  parameter int unsigned RUN_LEN  = 192,
  parameter int unsigned EXZ_T3   = 3,
  parameter int unsigned EXZ_E3   = 4,
  localparam int unsigned SW      = los_pkg::cnt_width(SPAN_LEN),
  localparam int unsigned RW      = los_pkg::cnt_width(RUN_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wipe,
  input  logic               active,    // LOS currently held
  input  logic               vld,
  input  los_pkg::line_mode_e mode,
  input  logic [RW-1:0]      run_adv,
  output logic               span_done
);
  localparam logic [RW-1:0] LIM_T3   = RW'(EXZ_T3);
  localparam logic [RW-1:0] LIM_E3   = RW'(EXZ_E3);
  localparam logic [SW-1:0] SPAN_MAX = SW'(SPAN_LEN);

  logic [SW-1:0] span_q;
  logic [SW-1:0] span_d;
  logic [SW-1:0] span_inc;
  logic [RW-1:0] exz_lim;
  logic          exz_hit;
  logic          span_ce;

  always_comb begin
    exz_lim   = (mode == los_pkg::LINE_E3) ? LIM_E3 : LIM_T3;
    exz_hit   = run_adv >= exz_lim;
    span_inc  = span_q + 1'b1;
    span_done = active && vld && !exz_hit && (span_inc == SPAN_MAX);
  end

  always_comb begin
    span_ce = wipe || !active || vld;
    if (wipe || !active || span_done || exz_hit) span_d = '0;
    else                                         span_d = span_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       span_q <= '0;
    else if (span_ce) span_q <= span_d;
  end
endmodule

// File: rtl/los_state.sv
// LOS state register and change-of-state strobe.
module los_state (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic declare,
  input  logic release_i,
  output logic los_q,
  output logic cos_q,
  output logic cos_set   // change decided this cycle (registered next edge)
);
  logic los_d;

  always_comb begin
    los_d = los_q;
    if (!enable)                  los_d = 1'b0;
    else if (!los_q && declare)   los_d = 1'b1;
    else if (los_q && release_i)  los_d = 1'b0;
    cos_set = enable && (los_d != los_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b0;
      cos_q <= 1'b0;
    end else begin
      los_q <= los_d;
      cos_q <= cos_set;
    end
  end
endmodule

// File: rtl/los_event_latch.sv
// Sticky change bit with set priority over clear, and the masked interrupt.
module los_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en,
  output logic sticky_q,
  output logic irq
);
  logic sticky_d;
  logic sticky_ce;

  always_comb begin
    sticky_ce = set_i || clr_i;
    sticky_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= 1'b0;
    else if (sticky_ce) sticky_q <= sticky_d;
  end

  assign irq = sticky_q && irq_en;
endmodule

// File: rtl/line_los_monitor.sv
module line_los_monitor #(
  parameter int unsigned RUN_LEN  = 192,
  parameter int unsigned SPAN_LEN = 192,
  parameter int unsigned EXZ_T3   = 3,
  parameter int unsigned EXZ_E3   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic mark_pos,
  input  logic mark_neg,
  input  logic mode_e3,
  input  logic dec_on,
  input  logic irq_en,
  input  logic cos_clr,
  output logic los_line,
  output logic los_flag,
  output logic cos_evt,
  output logic cos_sticky,
  output logic irq
);
  localparam int unsigned RW = los_pkg::cnt_width(RUN_LEN);

  logic               mark;
  logic               vld_g;
  logic [RW-1:0]      run_adv;
  logic               run_full;
  logic               span_done;
  logic               los_q;
  logic               cos_set;
  logic               wipe;
  los_pkg::line_mode_e mode;

  always_comb begin
    mark  = mark_pos || mark_neg;
    vld_g = smp_vld && dec_on;
    mode  = mode_e3 ? los_pkg::LINE_E3 : los_pkg::LINE_T3;
    wipe  = !dec_on || span_done;
  end

  los_zero_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .vld(vld_g), .mark(mark),
    .run_adv(run_adv), .run_full(run_full)
  );

  los_clean_span #(
    .SPAN_LEN(SPAN_LEN), .RUN_LEN(RUN_LEN), .EXZ_T3(EXZ_T3), .EXZ_E3(EXZ_E3)
  ) u_span (
    .clk(clk), .rst_n(rst_n), .wipe(!dec_on), .active(los_q), .vld(vld_g),
    .mode(mode), .run_adv(run_adv), .span_done(span_done)
  );

  los_state u_state (
    .clk(clk), .rst_n(rst_n), .enable(dec_on), .declare(run_full),
    .release_i(span_done), .los_q(los_q), .cos_q(cos_evt), .cos_set(cos_set)
  );

  los_event_latch u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(cos_set), .clr_i(cos_clr),
    .irq_en(irq_en), .sticky_q(cos_sticky), .irq(irq)
  );

  assign los_line = los_q;
  assign los_flag = los_q;
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic mark_pos,
  input logic mark_neg,
  input logic dec_on,
  input logic irq_en,
  input logic los_line,
  input logic los_flag,
  input logic cos_evt,
  input logic cos_sticky,
  input logic irq
);
  assert_mark_no_declare_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_on && smp_vld && (mark_pos || mark_neg) && !los_line) |=> !los_line);

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_on && !smp_vld) |=> $stable(los_line));

  assert_pin_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    los_line == los_flag);

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_on |=> (!los_line && !cos_evt));

  assert_rise_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_line) |-> (cos_evt && cos_sticky));

  assert_event_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cos_evt |=> !cos_evt);

  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_evt && irq_en) |-> irq);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind line_los_monitor los_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mark_pos(mark_pos),
  .mark_neg(mark_neg), .dec_on(dec_on), .irq_en(irq_en),
  .los_line(los_line), .los_flag(los_flag), .cos_evt(cos_evt),
  .cos_sticky(cos_sticky), .irq(irq)
);

// File: tb/tb_line_los_monitor.sv
module tb_line_los_monitor;
  localparam int PERIOD = 10;
  localparam int N = 192;

  logic clk = 1'b0;
  logic rst_n, smp_vld, mark_pos, mark_neg, mode_e3, dec_on, irq_en, cos_clr;
  logic los_line, los_flag, cos_evt, cos_sticky, irq;

  int checks = 0;
  int errors = 0;
  int mismatch = 0;

  always #(PERIOD/2) clk = ~clk;

  line_los_monitor dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mark_pos(mark_pos),
    .mark_neg(mark_neg), .mode_e3(mode_e3), .dec_on(dec_on), .irq_en(irq_en),
    .cos_clr(cos_clr), .los_line(los_line), .los_flag(los_flag),
    .cos_evt(cos_evt), .cos_sticky(cos_sticky), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic p, input logic n);
    smp_vld = v; mark_pos = p; mark_neg = n;
    @(posedge clk); #1;
    if (los_line != los_flag) mismatch++;
    cos_clr = 1'b0;
  endtask

  task automatic zeros(input int k);
    for (int i = 0; i < k; i++) tick(1'b1, 1'b0, 1'b0);
  endtask

  task automatic quiesce;
    dec_on = 1'b0; cos_clr = 1'b1;
    tick(1'b0, 1'b0, 1'b0);
    dec_on = 1'b1;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first, cnt, thr, exp_at, evt_bad;
    rst_n = 1'b0; smp_vld = 0; mark_pos = 0; mark_neg = 0; mode_e3 = 0;
    dec_on = 1'b1; irq_en = 1'b1; cos_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(los_line, 0, "R10 los_line");
    chk(los_flag, 0, "R10 los_flag");
    chk(cos_evt, 0, "R10 cos_evt");
    chk(cos_sticky, 0, "R10 cos_sticky");
    chk(irq, 0, "R10 irq");
    rst_n = 1'b1;

    // R1 declare threshold sweep, both modes
    for (int m = 0; m < 2; m++) begin
      for (int n = N - 3; n <= N + 3; n++) begin
        mode_e3 = m[0];
        quiesce();
        first = 0;
        for (int i = 1; i <= n; i++) begin
          tick(1'b1, 1'b0, 1'b0);
          if (first == 0 && los_line) first = i;
        end
        chk(first, (n >= N) ? N : 0, "R1 declare index");
      end
    end

    // R2 either polarity restarts the run
    for (int pol = 1; pol < 4; pol++) begin
      mode_e3 = 1'b0;
      quiesce();
      zeros(N - 1);
      tick(1'b1, pol[0], pol[1]);
      zeros(N - 1);
      chk(los_line, 0, "R2 no declare after mark");
      zeros(1);
      chk(los_line, 1, "R2 declare after fresh run");
    end

    // R3 unstrobed cycles ignored, even with marks on the inputs
    quiesce();
    first = 0; cnt = 0;
    for (int i = 1; i <= N; i++) begin
      tick(1'b0, 1'b1, 1'b1);
      if (los_line) first = -1;
      tick(1'b1, 1'b0, 1'b0);
      cnt++;
      if (first == 0 && los_line) first = cnt;
    end
    chk(first, N, "R3 declare index with idle cycles");
    // idle cycles do not advance the clean span
    for (int i = 0; i < 400; i++) tick(1'b0, 1'b1, 1'b0);
    chk(los_line, 1, "R3 idle cycles keep LOS");

    // R4 / R5 clear timing vs gap length
    for (int m = 0; m < 2; m++) begin
      for (int g = 1; g <= 6; g++) begin
        mode_e3 = m[0];
        thr = m ? 4 : 3;
        quiesce();
        zeros(N);
        chk(cos_evt, 1, "R8 event at declare");
        exp_at = (g < thr) ? N : 100 + g + N;
        first = 0; cnt = 0; evt_bad = 0;
        for (int i = 0; i < 100; i++) begin
          tick(1'b1, 1'b1, 1'b0); cnt++;
          if (!los_line && first == 0) first = cnt;
          if (cos_evt && los_line) evt_bad++;
        end
        for (int i = 0; i < g; i++) begin
          tick(1'b1, 1'b0, 1'b0); cnt++;
          if (!los_line && first == 0) first = cnt;
        end
        while (first == 0 && cnt < 600) begin
          tick(1'b1, 1'b0, 1'b1); cnt++;
          if (!los_line && first == 0) begin
            first = cnt;
            if (!cos_evt) evt_bad++;
          end
        end
        chk(first, exp_at, m ? "R5 clear index E3" : "R4 clear index DS3");
        chk(evt_bad, 0, "R8 event only on change");
      end
    end

    // R7 disable while LOS high
    mode_e3 = 1'b0;
    quiesce();
    zeros(N);
    chk(los_line, 1, "R7 setup LOS");
    dec_on = 1'b0;
    tick(1'b1, 1'b0, 1'b0);
    chk(los_line, 0, "R7 LOS low when off");
    chk(cos_evt, 0, "R7 no event when off");
    zeros(300);
    chk(los_line, 0, "R7 zeros ignored when off");
    dec_on = 1'b1;
    zeros(N - 1);
    chk(los_line, 0, "R7 full run after re-enable");
    // counters cleared by disable
    quiesce();
    zeros(150);
    dec_on = 1'b0; tick(1'b1, 1'b0, 1'b0); dec_on = 1'b1;
    zeros(50);
    chk(los_line, 0, "R7 partial run cleared");
    zeros(N - 50);
    chk(los_line, 1, "R7 declare after fresh 192");

    // R8 collision of clear and new event; R9 masking
    quiesce();
    chk(cos_sticky, 0, "R8 sticky cleared");
    zeros(N - 1);
    cos_clr = 1'b1;
    tick(1'b1, 1'b0, 1'b0);
    chk(cos_evt, 1, "R8 event with clear same edge");
    chk(cos_sticky, 1, "R8 set wins over clear");
    tick(1'b1, 1'b1, 1'b0);
    chk(cos_evt, 0, "R8 event one cycle");
    chk(cos_sticky, 1, "R8 sticky holds");
    irq_en = 1'b0; #1;
    chk(irq, 0, "R9 masked");
    irq_en = 1'b1; #1;
    chk(irq, 1, "R9 enabled");
    cos_clr = 1'b1;
    tick(1'b1, 1'b1, 1'b0);
    chk(cos_sticky, 0, "R8 clear alone");
    chk(irq, 0, "R9 follows sticky");

    chk(mismatch, 0, "R6 pin equals status");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule